// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a bus-mapped watchdog. A 32-bit counter counts upward on a slow tick enable. The tick rate can be divided by a power of two. When the counter wraps past all-ones, the block raises a one-cycle reset request and restarts from a programmable load value. Software keeps the system alive by writing the service register with a value that differs from the one it last wrote. Each such write reloads the counter. Writing the same value twice in a row does nothing, so a stuck loop that keeps writing one constant cannot hold off the reset.

The timer can only be started or stopped by writing two key words in order to the key register. While it runs, the control and load registers are frozen. Every write goes into a per-register posting stage and takes effect four slow ticks later. The stage raises a pending flag in the status register for that whole period. Software must poll that flag before it writes the same register again.

The key decoder is a four-state machine:

| State | Meaning | Transitions out |
|---|---|---|
| `KS_HALTED` | Stopped | `arm_on`: an applied 0xBBBB moves to `KS_ARMING`. Any other word stays here. |
| `KS_ARMING` | Stopped, first start key seen | `go`: 0x4444 moves to `KS_RUNNING`. `rearm_on`: 0xBBBB stays here. `abort_on`: any other word returns to `KS_HALTED`. |
| `KS_RUNNING` | Counting | `arm_off`: 0xAAAA moves to `KS_DISARMING`. Any other word stays here. |
| `KS_DISARMING` | Counting, first stop key seen | `halt`: 0x5555 moves to `KS_HALTED`. `rearm_off`: 0xAAAA stays here. `abort_off`: any other word returns to `KS_RUNNING`. |

Top module: `wdk_top`

## Requirements
- R1: After reset the timer is stopped and `rst_req` is low. The control, service and key registers read 0, the status register reads 0, and both the counter and the load register read 0xFFE20000. That value is about 60 s before a wrap at 32768 ticks per second.
- R2: A bus write to the control, load, service or key register sets that register's pending bit in the status register on the following cycle. The bits are: bit 0 control, bit 1 load, bit 2 service, bit 3 key. The write takes effect, and the bit clears, on the clock edge of the 4th tick after the write edge. A pending bit never clears on a cycle without a tick.
- R3: The timer starts only when the applied key writes are 0xBBBB followed by 0x4444. While stopped, the counter holds its value.
- R4: The timer stops only when the applied key writes are 0xAAAA followed by 0x5555. Any other order or value leaves it running.
- R5: Applied writes to the control and load registers take effect only while the timer is stopped. While it runs they leave both registers unchanged.
- R6: An applied service write whose value differs from the stored service value stores the new value, loads the counter from the load register and restarts the prescaler. An applied write of the same value changes nothing.
- R7: Control bit 0 enables the prescaler and control bits [3:1] hold a ratio exponent p. When the prescaler is enabled, the counter advances once every 2^p ticks. When it is disabled, the counter advances on every tick.
- R8: When a running counter advances from 0xFFFFFFFF, it takes the load value and `rst_req` is high for exactly the next cycle. `rst_req` is never high without a counting step on the previous edge.
- R9: Reads use these offsets: control 0x24, counter 0x28, load 0x2C, service 0x30, status 0x34, key 0x48. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle per slow period |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The hardest situations to reach from the ports are those that need the running state together with a long posting delay. Examples are a stop sequence broken by a stray word, a frozen-register write made while counting, and a wrap that lands near an applied service write. The stimulus makes wraps frequent by loading values just below all-ones. It polls the status register between writes, as a driver would. It replays the key and service corner cases under both a tick on every cycle and a sparse tick. A behavioural model steps the posting queues and counter each cycle, so every read and every `rst_req` cycle is compared.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int NREG     = 4;
    localparam int IDX_CTRL = 0;
    localparam int IDX_LOAD = 1;
    localparam int IDX_TRIG = 2;
    localparam int IDX_KEY  = 3;

    localparam logic [7:0] OFS_CTRL  = 8'h24;
    localparam logic [7:0] OFS_COUNT = 8'h28;
    localparam logic [7:0] OFS_LOAD  = 8'h2C;
    localparam logic [7:0] OFS_TRIG  = 8'h30;
    localparam logic [7:0] OFS_PEND  = 8'h34;
    localparam logic [7:0] OFS_KEY   = 8'h48;

    localparam logic [15:0] KEY_ARM_ON  = 16'hBBBB;
    localparam logic [15:0] KEY_GO      = 16'h4444;
    localparam logic [15:0] KEY_ARM_OFF = 16'hAAAA;
    localparam logic [15:0] KEY_HALT    = 16'h5555;

    typedef enum logic [1:0] {
        KS_HALTED,
        KS_ARMING,
        KS_RUNNING,
        KS_DISARMING
    } key_state_e;

    function automatic logic [7:0] post_offset(input int idx);
        logic [7:0] r;
        unique case (idx)
            IDX_CTRL: r = OFS_CTRL;
            IDX_LOAD: r = OFS_LOAD;
            IDX_TRIG: r = OFS_TRIG;
            default:  r = OFS_KEY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdk_post.sv
module wdk_post #(
    parameter int DW    = 32,
    parameter int DELAY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] commit_data
);
    localparam int CW = $clog2(DELAY + 1);

    typedef enum logic {PS_IDLE, PS_WAIT} post_state_e;

    post_state_e   state_q;
    logic [CW-1:0] left_q;
    logic [DW-1:0] data_q;
    logic          last_tick;

    assign last_tick = (state_q == PS_WAIT) && tick && (left_q == CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            left_q  <= '0;
            data_q  <= '0;
        end else if (wr_en) begin
            state_q <= PS_WAIT;
            left_q  <= CW'(DELAY);
            data_q  <= wr_data;
        end else begin
            unique case (state_q)
                PS_IDLE: state_q <= PS_IDLE;
                PS_WAIT: begin
                    if (tick) begin
                        left_q <= left_q - CW'(1);
                        if (left_q == CW'(1)) state_q <= PS_IDLE;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pending     = (state_q == PS_WAIT);
        commit      = last_tick;
        commit_data = data_q;
    end

endmodule

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
    import wdk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  logic [DW-1:0] key,
    output logic          running
);
    localparam logic [DW-1:0] W_ARM_ON  = DW'(KEY_ARM_ON);
    localparam logic [DW-1:0] W_GO      = DW'(KEY_GO);
    localparam logic [DW-1:0] W_ARM_OFF = DW'(KEY_ARM_OFF);
    localparam logic [DW-1:0] W_HALT    = DW'(KEY_HALT);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (apply) begin
            unique case (state_q)
                KS_HALTED:
                    state_d = (key == W_ARM_ON) ? KS_ARMING : KS_HALTED;
                KS_ARMING:
                    if (key == W_GO)           state_d = KS_RUNNING;
                    else if (key == W_ARM_ON)  state_d = KS_ARMING;
                    else                       state_d = KS_HALTED;
                KS_RUNNING:
                    state_d = (key == W_ARM_OFF) ? KS_DISARMING : KS_RUNNING;
                KS_DISARMING:
                    if (key == W_HALT)         state_d = KS_HALTED;
                    else if (key == W_ARM_OFF) state_d = KS_DISARMING;
                    else                       state_d = KS_RUNNING;
                default: state_d = KS_HALTED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_HALTED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            KS_RUNNING, KS_DISARMING: running = 1'b1;
            default:                  running = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdk_timer.sv
module wdk_timer #(
    parameter int            DW       = 32,
    parameter int            PTV_W    = 3,
    parameter logic [DW-1:0] DEF_LOAD = 32'hFFE2_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    input  logic             reload,
    input  logic [DW-1:0]    load_val,
    output logic [DW-1:0]    count,
    output logic             rst_req
);
    localparam int            PRE_W   = (1 << PTV_W) - 1;
    localparam logic [DW-1:0] ALL_ONE = '1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic [DW-1:0]    count_q;
    logic             req_q;
    logic             step;

    generate
        if (PRE_W > 1) begin : g_wide
            always_comb
                pre_lim = pre_en ? ((PRE_W'(1) << ptv) - PRE_W'(1)) : '0;
        end else begin : g_narrow
            always_comb pre_lim = pre_en ? PRE_W'(ptv) : '0;
        end
    endgenerate

    assign step = running && tick && (pre_q == pre_lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!running || reload) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= (pre_q == pre_lim) ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= DEF_LOAD;
            req_q   <= 1'b0;
        end else begin
            req_q <= step && (count_q == ALL_ONE);
            if (reload)                   count_q <= load_val;
            else if (step && count_q == ALL_ONE) count_q <= load_val;
            else if (step)                count_q <= count_q + DW'(1);
        end
    end

    assign count   = count_q;
    assign rst_req = req_q;

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int            DW         = 32,
    parameter int            AW         = 8,
    parameter int            PTV_W      = 3,
    parameter int            POST_DELAY = 4,
    parameter logic [DW-1:0] DEF_LOAD   = 32'hFFE2_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req
);
    localparam int CTRL_W = PTV_W + 1;

    logic [NREG-1:0] wr_hit;
    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] commit;
    logic [DW-1:0]   post_data [NREG];

    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     load_q;
    logic [DW-1:0]     trig_q;
    logic [DW-1:0]     key_q;
    logic [DW-1:0]     count_w;
    logic              run_w;
    logic              reload;

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_post
            assign wr_hit[gi] = bus_we && (bus_addr == AW'(post_offset(gi)));
            wdk_post #(.DW(DW), .DELAY(POST_DELAY)) u_post (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .wr_en      (wr_hit[gi]),
                .wr_data    (bus_wdata),
                .pending    (pend_q[gi]),
                .commit     (commit[gi]),
                .commit_data(post_data[gi])
            );
        end
    endgenerate

    assign reload = commit[IDX_TRIG] && (post_data[IDX_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= DEF_LOAD;
            trig_q <= '0;
            key_q  <= '0;
        end else begin
            if (commit[IDX_CTRL] && !run_w) ctrl_q <= post_data[IDX_CTRL][CTRL_W-1:0];
            if (commit[IDX_LOAD] && !run_w) load_q <= post_data[IDX_LOAD];
            if (reload)                     trig_q <= post_data[IDX_TRIG];
            if (commit[IDX_KEY])            key_q  <= post_data[IDX_KEY];
        end
    end

    wdk_keyfsm #(.DW(DW)) u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (commit[IDX_KEY]),
        .key    (post_data[IDX_KEY]),
        .running(run_w)
    );

    wdk_timer #(.DW(DW), .PTV_W(PTV_W), .DEF_LOAD(DEF_LOAD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .running (run_w),
        .pre_en  (ctrl_q[0]),
        .ptv     (ctrl_q[CTRL_W-1:1]),
        .reload  (reload),
        .load_val(load_q),
        .count   (count_w),
        .rst_req (rst_req)
    );

    always_comb begin
        unique case (bus_addr)
            AW'(OFS_CTRL):  bus_rdata = DW'(ctrl_q);
            AW'(OFS_COUNT): bus_rdata = count_w;
            AW'(OFS_LOAD):  bus_rdata = load_q;
            AW'(OFS_TRIG):  bus_rdata = trig_q;
            AW'(OFS_PEND):  bus_rdata = DW'(pend_q);
            AW'(OFS_KEY):   bus_rdata = key_q;
            default:        bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          rst_req,
    input logic [NREG-1:0] pend,
    input logic          running,
    input logic [DW-1:0] count
);

    assert_pend_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_LOAD)) |=> pend[IDX_LOAD]);

    assert_pend_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && pend != '0) |=> ((pend & $past(pend)) == $past(pend)));

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !pend[IDX_TRIG]) |=> $stable(count));

    assert_run_by_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(running) |-> $past(pend[IDX_KEY] && tick));

    assert_req_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(running && tick));

endmodule

bind wdk_top wdk_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .rst_req (rst_req),
    .pend    (pend_q),
    .running (run_w),
    .count   (count_w)
);

// File: tb/wdk_top_bench.sv
module wdk_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int vectors = 0;
    int fails = 0;
    int tick_div = 1;
    int cyc = 0;
    int req_seen = 0;
    string phase = "R1";

    wdk_top u_wdk_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        #1;
        cyc++;
        tick = ((cyc % tick_div) == 0);
    end

    // behavioural reference model
    logic [31:0] m_ctrl, m_load, m_trig, m_cnt, m_key;
    int          m_state;
    int          m_pre;
    logic        m_rreq;
    logic [31:0] q_data [4];
    int          q_left [4];
    bit          q_on   [4];

    function automatic logic [7:0] ofs(input int k);
        case (k)
            0: return 8'h24;
            1: return 8'h2C;
            2: return 8'h30;
            default: return 8'h48;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h24: return m_ctrl;
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h30: return m_trig;
            8'h34: return {28'h0, q_on[3], q_on[2], q_on[1], q_on[0]};
            8'h48: return m_key;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit          run, step, reload;
        bit          cm [4];
        logic [31:0] cd [4];
        logic [31:0] old_load;
        int          lim;
        if (!rst_n) begin
            m_ctrl = 0; m_load = 32'hFFE2_0000; m_trig = 0; m_key = 0;
            m_cnt = 32'hFFE2_0000; m_state = 0; m_pre = 0; m_rreq = 0;
            for (int k = 0; k < 4; k++) begin q_on[k] = 0; q_left[k] = 0; q_data[k] = 0; end
        end else begin
            run = (m_state >= 2);
            lim = m_ctrl[0] ? ((1 << m_ctrl[3:1]) - 1) : 0;
            old_load = m_load;
            for (int k = 0; k < 4; k++) begin
                cm[k] = q_on[k] && tick && (q_left[k] == 1);
                cd[k] = q_data[k];
                if (bus_we && bus_addr == ofs(k)) begin
                    q_on[k] = 1; q_left[k] = 4; q_data[k] = bus_wdata;
                end else if (q_on[k] && tick) begin
                    if (q_left[k] == 1) q_on[k] = 0;
                    q_left[k] = q_left[k] - 1;
                end
            end
            reload = 0;
            if (cm[0] && !run) m_ctrl = cd[0] & 32'hF;
            if (cm[1] && !run) m_load = cd[1];
            if (cm[2] && cd[2] != m_trig) begin m_trig = cd[2]; reload = 1; end
            if (cm[3]) begin
                m_key = cd[3];
                case (m_state)
                    0: m_state = (cd[3] == 32'hBBBB) ? 1 : 0;
                    1: m_state = (cd[3] == 32'h4444) ? 2 : (cd[3] == 32'hBBBB) ? 1 : 0;
                    2: m_state = (cd[3] == 32'hAAAA) ? 3 : 2;
                    default: m_state = (cd[3] == 32'h5555) ? 0 : (cd[3] == 32'hAAAA) ? 3 : 2;
                endcase
            end
            step = run && tick && (m_pre == lim);
            m_rreq = step && (m_cnt == 32'hFFFF_FFFF);
            if (reload) m_cnt = old_load;
            else if (step) m_cnt = (m_cnt == 32'hFFFF_FFFF) ? old_load : m_cnt + 1;
            if (!run || reload) m_pre = 0;
            else if (tick) m_pre = (m_pre == lim) ? 0 : m_pre + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (rst_req) req_seen++;
            if (bus_rdata !== m_read(bus_addr) || rst_req !== m_rreq) begin
                fails++;
                $display("FAIL %s model addr=%h rdata=%h exp=%h rst_req=%b exp=%b",
                         phase, bus_addr, bus_rdata, m_read(bus_addr), rst_req, m_rreq);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic wr_wait(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] v;
        wr(a, d);
        v = 1;
        for (int n = 0; n < 200 && v != 0; n++) rd(8'h34, v);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        logic [31:0] v, c0, c1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        phase = "R1";
        rd(8'h24, v); chk("R1 ctrl", v, 0);
        rd(8'h28, v); chk("R1 count", v, 32'hFFE2_0000);
        rd(8'h2C, v); chk("R1 load", v, 32'hFFE2_0000);
        rd(8'h30, v); chk("R1 service", v, 0);
        rd(8'h34, v); chk("R1 status", v, 0);
        rd(8'h48, v); chk("R1 key", v, 0);
        chk("R1 rst_req", {31'h0, rst_req}, 0);

        // R9 undefined offsets
        phase = "R9";
        rd(8'h00, v); chk("R9 offset 0x00", v, 0);
        rd(8'h40, v); chk("R9 offset 0x40", v, 0);

        // R2 posting delay with a tick every cycle
        phase = "R2";
        wr(8'h2C, 32'hFFFF_FFF0);
        rd(8'h34, v); chk("R2 pending after 1 tick", v, 32'h2);
        rd(8'h34, v); chk("R2 pending after 2 ticks", v, 32'h2);
        rd(8'h34, v); chk("R2 pending after 3 ticks", v, 32'h2);
        rd(8'h34, v); chk("R2 cleared on 4th tick", v, 32'h0);
        rd(8'h2C, v); chk("R2 load applied", v, 32'hFFFF_FFF0);

        // R6 service reload while stopped
        phase = "R6";
        wr_wait(8'h30, 32'h1234);
        rd(8'h28, v); chk("R6 reload from load", v, 32'hFFFF_FFF0);

        // R3 start sequence
        phase = "R3";
        wr_wait(8'h48, 32'hBBBB);
        rd(8'h28, c0); repeat (3) @(posedge clk);
        rd(8'h28, c1); chk("R3 half sequence holds", c1, c0);
        wr_wait(8'h48, 32'h4444);
        rd(8'h28, c0); rd(8'h28, c1);
        chk("R3 counting after start", {31'h0, c1 != c0}, 1);

        // R8 wrap produces reset request
        phase = "R8";
        req_seen = 0;
        repeat (40) @(posedge clk);
        chk("R8 reset request seen", {31'h0, req_seen > 0}, 1);

        // R5 frozen registers while running
        phase = "R5";
        wr_wait(8'h24, 32'hF);
        rd(8'h24, v); chk("R5 ctrl frozen", v, 0);
        wr_wait(8'h2C, 32'h0);
        rd(8'h2C, v); chk("R5 load frozen", v, 32'hFFFF_FFF0);

        // R4 bad stop sequences
        phase = "R4";
        wr_wait(8'h48, 32'h5555);
        wr_wait(8'h48, 32'hAAAA);
        wr_wait(8'h48, 32'h1234);
        wr_wait(8'h48, 32'h5555);
        rd(8'h28, c0); rd(8'h28, c1);
        chk("R4 still running after wrong order", {31'h0, c1 != c0}, 1);
        wr_wait(8'h48, 32'hAAAA);
        wr_wait(8'h48, 32'h5555);
        rd(8'h28, c0); repeat (5) @(posedge clk);
        rd(8'h28, c1); chk("R4 stopped after proper sequence", c1, c0);

        // R7 prescaler divide by 4
        phase = "R7";
        wr_wait(8'h24, 32'h5);
        rd(8'h24, v); chk("R5 ctrl accepted while stopped", v, 32'h5);
        wr_wait(8'h2C, 32'hFFFF_FF00);
        wr_wait(8'h30, 32'hEDCB);
        wr_wait(8'h48, 32'hBBBB);
        wr_wait(8'h48, 32'h4444);
        rd(8'h28, c0);
        repeat (15) @(posedge clk);
        rd(8'h28, c1);
        chk("R7 four steps in 16 ticks", c1 - c0, 4);

        // R6 repeated service value does not reload
        phase = "R6";
        rd(8'h28, c0);
        wr_wait(8'h30, 32'hEDCB);
        rd(8'h28, c1);
        chk("R6 same value no reload", {31'h0, (c1 >= c0) && (c1 != 32'hFFFF_FF00)}, 1);
        wr_wait(8'h30, 32'h1234);
        rd(8'h30, v); chk("R6 new value stored", v, 32'h1234);

        // sparse tick replay
        phase = "R2";
        tick_div = 3;
        wr_wait(8'h30, 32'hEDCB);
        wr_wait(8'h48, 32'hAAAA);
        wr_wait(8'h48, 32'hAAAA);
        wr_wait(8'h48, 32'h5555);
        rd(8'h34, v); chk("R2 status idle", v, 0);
        phase = "R7";
        wr_wait(8'h24, 32'h0);
        wr_wait(8'h2C, 32'hFFFF_FFF8);
        wr_wait(8'h30, 32'h1234);
        wr_wait(8'h48, 32'hBBBB);
        wr_wait(8'h48, 32'hBBBB);
        wr_wait(8'h48, 32'h4444);
        phase = "R8";
        repeat (120) @(posedge clk);

        #1;
        finish_run();
    end

endmodule